// File: doc/BRIEF.md
# Amplifier Serial Control Receiver

This block receives control words for an audio amplifier over three wires: serial data, serial clock and an active-high enable. All three inputs are asynchronous to the system clock. Each one passes through a synchronizer, and the block detects edges on the serial clock and on enable in the system clock domain.

While enable is high, each rising serial clock edge shifts in one bit, least significant bit first. Only the first eight bits of a frame count. When enable falls after a full word has arrived, the word is copied into held registers. The low three bits form the output mode and the upper five bits form the gain step.

The held mode is decoded into control lines:
- a global shutdown flag;
- enable and mute for the mono speaker path;
- enable and source selection for the stereo headset path.

The gain step is turned into signed gains in half-decibel units for the line path and the phone path. A one-cycle strobe marks every change of the held word.

Top module: `amp_serial_ctl`

## Requirements
- R1: After reset the held mode is 0 and the gain code is 0. Shutdown is 1, every speaker and headset control is 0, and the strobe is 0.
- R2: Frame bit i (i = 0 first) is word bit i. Word bits [2:0] give the mode and bits [7:3] give the gain code.
- R3: The held registers change only on a falling edge of enable. A complete word does not appear on the outputs while enable stays high.
- R4: A frame with fewer than eight rising serial clock edges leaves the held registers unchanged and gives no strobe.
- R5: In a frame with more than eight clock edges, only the first eight bits are used.
- R6: A rising edge of enable clears the bit count and the shift register. Bits from an earlier aborted frame never mix into a later frame.
- R7: The strobe `upd_o` is high for one cycle, in the same cycle the new held value first shows. It pulses only when the held word actually changes, so rewriting the same word gives no pulse.
- R8: `shutdown_o` is 1 only in mode 0. `spk_en_o` equals mode bit 0. `spk_mute_o` is 1 for modes 2, 4 and 6.
- R9: `hs_phone_sel_o` equals mode bit 1 and `hs_line_sel_o` equals mode bit 2. `hs_en_o` is 1 when either select is 1.
- R10: `line_gain_o` = -69 + 3*code and `phone_gain_o` = line gain - 12, both signed, in half-dB units.
- R11: A serial clock rise that is detected in the same cycle as the enable fall is not counted as a data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Frame enable, active high, asynchronous |
| mode_o | output | 3 | Held output mode |
| gain_o | output | 5 | Held gain code |
| upd_o | output | 1 | One-cycle pulse when the held word changes |
| shutdown_o | output | 1 | All outputs powered down |
| spk_en_o | output | 1 | Speaker path active |
| spk_mute_o | output | 1 | Speaker path muted |
| hs_en_o | output | 1 | Headset path active |
| hs_phone_sel_o | output | 1 | Headset takes the phone input |
| hs_line_sel_o | output | 1 | Headset takes the stereo line inputs |
| line_gain_o | output | 8 | Line path gain, signed half-dB |
| phone_gain_o | output | 8 | Phone path gain, signed half-dB |

## Verification
Two events can land in the same system clock cycle: a rising serial clock edge that would shift in a bit, and the enable fall that closes the frame. The bench provokes this by sending seven bits and then switching the eighth clock high and enable low in one step. Both signals pass through synchronizers of equal depth, so the two edges are detected together. The outcome is judged at the ports: the held mode and gain must stay as they were and the strobe must not pulse, because the eighth bit is not counted.

// File: rtl/amp_ctl_pkg.sv
package amp_ctl_pkg;
  localparam int MODE_W = 3;

  typedef logic [MODE_W-1:0] mode_t;

  typedef struct packed {
    logic shutdown;
    logic spk_en;
    logic spk_mute;
    logic hs_en;
    logic hs_phone;
    logic hs_line;
  } route_t;
endpackage

// File: rtl/amp_in_sync.sv
module amp_in_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[s] <= '0;
      end else begin
        stg_q[s] <= (s == 0) ? async_i : stg_q[(s == 0) ? 0 : s - 1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/amp_frame_shift.sv
module amp_frame_shift #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_lvl,
  input  logic              en_rise,
  input  logic              sclk_rise,
  input  logic              dat,
  output logic [WORD_W-1:0] word_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              full;
  logic              step_en;

  assign full    = (cnt_q == CNT_FULL);
  assign step_en = en_rise | (en_lvl & sclk_rise & ~full);

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (en_rise) begin
      cnt_d = '0;
      sh_d  = '0;
    end else if (en_lvl && sclk_rise && !full) begin
      sh_d  = {dat, sh_q[WORD_W-1:1]};
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (step_en) begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign word_o = sh_q;
  assign full_o = full;

  // R5
  cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == '0 || cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/amp_ctl_decode.sv
module amp_ctl_decode
  import amp_ctl_pkg::*;
#(
  parameter int GAIN_W        = 5,
  parameter int HDB_W         = 8,
  parameter int LINE_BASE_HDB = -69,
  parameter int STEP_HDB      = 3,
  parameter int PHONE_OFS_HDB = -12
) (
  input  mode_t                    mode,
  input  logic [GAIN_W-1:0]        gain,
  output route_t                   route,
  output logic signed [HDB_W-1:0]  line_hdb,
  output logic signed [HDB_W-1:0]  phone_hdb
);
  always_comb begin
    route.shutdown = (mode == '0);
    route.spk_en   = mode[0];
    route.spk_mute = (mode != '0) & ~mode[0];
    route.hs_phone = mode[1];
    route.hs_line  = mode[2];
    route.hs_en    = mode[1] | mode[2];
  end

  always_comb begin
    line_hdb  = HDB_W'(LINE_BASE_HDB + STEP_HDB * int'(gain));
    phone_hdb = HDB_W'(LINE_BASE_HDB + PHONE_OFS_HDB + STEP_HDB * int'(gain));
  end
endmodule

// File: rtl/amp_serial_ctl.sv
module amp_serial_ctl
  import amp_ctl_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int GAIN_W        = 5,
  parameter int HDB_W         = 8,
  parameter int LINE_BASE_HDB = -69,
  parameter int STEP_HDB      = 3,
  parameter int PHONE_OFS_HDB = -12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ser_clk,
  input  logic                     ser_dat,
  input  logic                     ser_en,
  output logic [MODE_W-1:0]        mode_o,
  output logic [GAIN_W-1:0]        gain_o,
  output logic                     upd_o,
  output logic                     shutdown_o,
  output logic                     spk_en_o,
  output logic                     spk_mute_o,
  output logic                     hs_en_o,
  output logic                     hs_phone_sel_o,
  output logic                     hs_line_sel_o,
  output logic signed [HDB_W-1:0]  line_gain_o,
  output logic signed [HDB_W-1:0]  phone_gain_o
);
  localparam int WORD_W = MODE_W + GAIN_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Bit order of the synchronized vector: [0] clock, [1] data, [2] enable.
  logic [2:0] in_sync, in_prev;

  amp_in_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({ser_en, ser_dat, ser_clk}),
    .sync_o  (in_sync),
    .prev_o  (in_prev)
  );

  logic sclk_rise, en_rise, en_fall;
  assign sclk_rise = in_sync[0] & ~in_prev[0];
  assign en_rise   = in_sync[2] & ~in_prev[2];
  assign en_fall   = ~in_sync[2] & in_prev[2];

  logic [WORD_W-1:0] word;
  logic              full;

  amp_frame_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en_lvl    (in_sync[2]),
    .en_rise   (en_rise),
    .sclk_rise (sclk_rise),
    .dat       (in_sync[1]),
    .word_o    (word),
    .full_o    (full)
  );

  logic [WORD_W-1:0] held_q, held_d;
  logic              upd_q, upd_d;
  logic              load;

  assign load = en_fall & full;

  always_comb begin
    held_d = held_q;
    upd_d  = 1'b0;
    if (load) begin
      held_d = word;
      upd_d  = (word != held_q);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      held_q <= '0;
    end else if (load) begin
      held_q <= held_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      upd_q <= 1'b0;
    end else begin
      upd_q <= upd_d;
    end
  end

  route_t route;

  amp_ctl_decode #(
    .GAIN_W        (GAIN_W),
    .HDB_W         (HDB_W),
    .LINE_BASE_HDB (LINE_BASE_HDB),
    .STEP_HDB      (STEP_HDB),
    .PHONE_OFS_HDB (PHONE_OFS_HDB)
  ) u_decode (
    .mode      (held_q[MODE_W-1:0]),
    .gain      (held_q[WORD_W-1:MODE_W]),
    .route     (route),
    .line_hdb  (line_gain_o),
    .phone_hdb (phone_gain_o)
  );

  assign mode_o         = held_q[MODE_W-1:0];
  assign gain_o         = held_q[WORD_W-1:MODE_W];
  assign upd_o          = upd_q;
  assign shutdown_o     = route.shutdown;
  assign spk_en_o       = route.spk_en;
  assign spk_mute_o     = route.spk_mute;
  assign hs_en_o        = route.hs_en;
  assign hs_phone_sel_o = route.hs_phone;
  assign hs_line_sel_o  = route.hs_line;

  // R4
  load_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(held_q) |-> $past(full));

  // R7
  held_change_upd_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(held_q) |-> upd_o);

  // R7
  upd_means_change_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_o |-> !$stable(held_q));

  // R8
  spk_excl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(spk_en_o && spk_mute_o));

  // R8
  shutdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    shutdown_o |-> !(spk_en_o || spk_mute_o || hs_en_o));
endmodule

// File: tb/amp_serial_ctl_tb.sv
module amp_serial_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic ser_clk, ser_dat, ser_en;
  logic [2:0] mode_o;
  logic [4:0] gain_o;
  logic upd_o, shutdown_o, spk_en_o, spk_mute_o, hs_en_o, hs_phone_sel_o, hs_line_sel_o;
  logic signed [7:0] line_gain_o, phone_gain_o;

  int checks = 0;
  int fails  = 0;
  int upd_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  amp_serial_ctl dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .ser_clk        (ser_clk),
    .ser_dat        (ser_dat),
    .ser_en         (ser_en),
    .mode_o         (mode_o),
    .gain_o         (gain_o),
    .upd_o          (upd_o),
    .shutdown_o     (shutdown_o),
    .spk_en_o       (spk_en_o),
    .spk_mute_o     (spk_mute_o),
    .hs_en_o        (hs_en_o),
    .hs_phone_sel_o (hs_phone_sel_o),
    .hs_line_sel_o  (hs_line_sel_o),
    .line_gain_o    (line_gain_o),
    .phone_gain_o   (phone_gain_o)
  );

  always @(posedge clk) if (rst_n && upd_o) upd_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_open();
    ser_en = 1'b1;
    cyc(4);
  endtask

  task automatic put_bit(input bit b);
    ser_dat = b;
    cyc(4);
    ser_clk = 1'b1;
    cyc(4);
    ser_clk = 1'b0;
  endtask

  task automatic frame_close();
    cyc(4);
    ser_en = 1'b0;
    cyc(8);
  endtask

  task automatic send(input logic [15:0] bits, input int n);
    frame_open();
    for (int i = 0; i < n; i++) put_bit(bits[i]);
    frame_close();
  endtask

  task automatic check_held(input string tag, input int m, input int g);
    chk({tag, " mode"}, int'(mode_o), m);
    chk({tag, " gain"}, int'(gain_o), g);
  endtask

  task automatic t_reset();
    chk("R1 mode", int'(mode_o), 0);
    chk("R1 gain", int'(gain_o), 0);
    chk("R1 shutdown", int'(shutdown_o), 1);
    chk("R1 routes", int'({spk_en_o, spk_mute_o, hs_en_o, hs_phone_sel_o, hs_line_sel_o}), 0);
    chk("R1 strobe", int'(upd_o), 0);
  endtask

  task automatic t_basic();
    int u0 = upd_cnt;
    send(16'h005D, 8);
    check_held("R2 word 0x5D", 5, 11);
    chk("R7 one pulse", upd_cnt - u0, 1);
    chk("R10 line", int'(line_gain_o), -36);
    chk("R10 phone", int'(phone_gain_o), -48);
  endtask

  task automatic t_gain_ends();
    send(16'h00F9, 8);
    check_held("R10 top", 1, 31);
    chk("R10 line top", int'(line_gain_o), 24);
    chk("R10 phone top", int'(phone_gain_o), 12);
    send(16'h0002, 8);
    chk("R10 line bottom", int'(line_gain_o), -69);
    chk("R10 phone bottom", int'(phone_gain_o), -81);
  endtask

  task automatic t_hold_until_fall();
    int u0 = upd_cnt;
    logic [7:0] w = 8'hA3;
    frame_open();
    for (int i = 0; i < 8; i++) put_bit(w[i]);
    cyc(10);
    check_held("R3 still open", 2, 0);
    chk("R3 no strobe yet", upd_cnt - u0, 0);
    frame_close();
    check_held("R3 after fall", 3, 20);
  endtask

  task automatic t_short();
    int u0 = upd_cnt;
    send(16'h001F, 5);
    check_held("R4 short frame", 3, 20);
    chk("R4 no strobe", upd_cnt - u0, 0);
  endtask

  task automatic t_restart();
    send(16'h0015, 5);
    send(16'h0046, 8);
    check_held("R6 fresh frame", 6, 8);
  endtask

  task automatic t_long();
    send(16'h072C, 11);
    check_held("R5 overlong", 4, 5);
  endtask

  task automatic t_same_word();
    int u0 = upd_cnt;
    int hi = 0;
    send(16'h002C, 8);
    chk("R7 repeat no pulse", upd_cnt - u0, 0);
    u0 = upd_cnt;
    frame_open();
    for (int i = 0; i < 8; i++) put_bit(i[0]);
    cyc(4);
    ser_en = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (upd_o) begin
        hi++;
        chk("R7 strobe with new value", int'(mode_o), 2);
      end
    end
    chk("R7 pulse width", hi, 1);
    chk("R7 changed pulse", upd_cnt - u0, 1);
  endtask

  task automatic t_coincide();
    int u0 = upd_cnt;
    logic [7:0] w = 8'hFF;
    frame_open();
    for (int i = 0; i < 7; i++) put_bit(w[i]);
    ser_dat = 1'b1;
    cyc(4);
    ser_clk = 1'b1;
    ser_en  = 1'b0;
    cyc(4);
    ser_clk = 1'b0;
    cyc(8);
    check_held("R11 coincident edge", 2, 10);
    chk("R11 no strobe", upd_cnt - u0, 0);
  endtask

  task automatic t_decode();
    for (int m = 0; m < 8; m++) begin
      logic [2:0] mb = 3'(m);
      send(16'(8'h38 | m), 8);
      chk("R8 shutdown", int'(shutdown_o), int'(m == 0));
      chk("R8 spk_en", int'(spk_en_o), int'(mb[0]));
      chk("R8 spk_mute", int'(spk_mute_o), int'(m != 0 && !mb[0]));
      chk("R9 hs_en", int'(hs_en_o), int'(mb[1] | mb[2]));
      chk("R9 phone sel", int'(hs_phone_sel_o), int'(mb[1]));
      chk("R9 line sel", int'(hs_line_sel_o), int'(mb[2]));
    end
  endtask

  initial begin
    rst_n = 1'b0;
    ser_clk = 1'b0;
    ser_dat = 1'b0;
    ser_en = 1'b0;
    cyc(5);
    t_reset();
    rst_n = 1'b1;
    cyc(5);
    t_reset();
    t_basic();
    t_gain_ends();
    t_hold_until_fall();
    t_short();
    t_restart();
    t_long();
    t_same_word();
    send(16'h0052, 8);
    t_coincide();
    t_decode();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule